// File: doc/BRIEF.md
# Interlaced Character-Row Vertical Timing Generator

This block produces the vertical timing of a text-mode display controller that measures the screen in character rows. A field is built from a programmed number of character rows, each a programmed number of scanlines tall. A fine-adjust count of extra scanlines follows the last row. The block advances on a once-per-scanline strobe from the horizontal timing logic. A second strobe, which arrives halfway through each scanline, is used to place the vertical sync half a line later in alternate fields when interlace is selected. In that case two fields together form one frame, and a flag shows which field is being scanned.

All programming inputs go to a shadow copy, which is loaded only at the field boundary. A change made partway through a field therefore never disturbs the field in progress. When interlace is first switched on, the field order is fixed: the first interlaced field is always the odd one.

Top module: `crtc_vtiming`

## Requirements
- R1: `line_cnt` starts at 0 and advances by one on each `line_stb`. After the last scanline of the field it returns to 0. A field lasts (row_total+1)·(row_height+1)+fine_adj scanlines, so row_total 38 with row_height 7 and fine_adj 0 gives 312.
- R2: `ras_cnt` counts 0..row_height inside a row. When it passes row_height, `row_cnt` steps by one and `ras_cnt` returns to 0. Both change only on `line_stb`. During fine-adjust lines, `row_cnt` holds row_total and `ras_cnt` is 0.
- R3: After the scanlines of the last row, exactly fine_adj extra scanlines are added before the wrap. A value of 0 adds none.
- R4: All programming inputs are sampled only at a field boundary. A boundary is the `line_stb` that ends the last scanline, or the first `line_stb` after reset, which restarts line 0 with the sampled values. A change made within a field has no effect on that field.
- R5: `vblank` is high while `row_cnt` ≥ disp_rows or during fine-adjust lines, and low otherwise. This makes it low at line 0 whenever disp_rows > 0.
- R6: In a field without the half-line shift, `vsync` goes high two clocks after the `line_stb` that starts scanline sync_row·(row_height+1), provided sync_row ≤ row_total. It stays high for sync_len scanline periods. A sync_len of 0 gives no sync.
- R7: In an even interlaced field, `vsync` goes high one clock after the `half_stb` within that same scanline. It stays high for sync_len half-strobe periods, so the pulse is shifted by half a line.
- R8: A `scan_mode` of 2'b11 selects interlace. While interlace stays selected, `field_odd` toggles at every boundary and changes only on `line_stb`.
- R9: At the boundary where interlace becomes active, `field_odd` is set to 1 (odd). With `scan_mode` 0, 1 or 2, `field_odd` stays 1 and no half-line shift is applied.
- R10: While `rst_n` is low, the outputs are: `line_cnt`, `row_cnt` and `ras_cnt` 0; `vsync` 0; `vblank` 1; `field_odd` 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_stb | input | 1 | One-cycle pulse at the start of each scanline |
| half_stb | input | 1 | One-cycle pulse at the middle of each scanline |
| row_total | input | 8 | Character rows per field minus one |
| row_height | input | 5 | Scanlines per character row minus one |
| fine_adj | input | 5 | Extra scanlines after the last row |
| disp_rows | input | 8 | Number of displayed character rows |
| sync_row | input | 8 | Row in which vertical sync begins |
| sync_len | input | 4 | Vertical sync length in scanlines |
| scan_mode | input | 2 | 2'b11 interlaced, other values progressive |
| line_cnt | output | 14 | Scanline index within the field |
| row_cnt | output | 8 | Character row index |
| ras_cnt | output | 5 | Scanline index within the row |
| vblank | output | 1 | Vertical blanking |
| vsync | output | 1 | Vertical sync |
| field_odd | output | 1 | 1 for the odd field, 0 for the even field |

## Verification
The assertions assume that `line_stb` and `half_stb` never pulse in the same cycle, and that exactly one half strobe falls between two line strobes. The sync-edge check relies on that spacing. The bench keeps to this by issuing a line strobe every eight clocks, with the half strobe four clocks after it. It also places every programmed sync pulse well inside a single field, so no pulse straddles a boundary where the half-line shift changes. The reference model assumes the same conditions when it predicts each clock.

// File: rtl/crtc_vt_pkg.sv
package crtc_vt_pkg;
  localparam int ROW_W  = 8;
  localparam int RAS_W  = 5;
  localparam int FINE_W = 5;
  localparam int SLEN_W = 4;
  localparam int LINE_W = ROW_W + RAS_W + 1;
  localparam logic [1:0] MODE_ILACE = 2'b11;

  typedef struct packed {
    logic [ROW_W-1:0]  tot;
    logic [RAS_W-1:0]  ht;
    logic [FINE_W-1:0] fine;
    logic [ROW_W-1:0]  disp;
    logic [ROW_W-1:0]  srow;
    logic [SLEN_W-1:0] slen;
    logic              ilace;
  } vt_cfg_t;

  typedef struct packed {
    logic [ROW_W-1:0]  row;
    logic [RAS_W-1:0]  ras;
    logic [FINE_W-1:0] fcnt;
    logic              in_fine;
    logic [LINE_W-1:0] line;
  } vt_pos_t;
endpackage

// File: rtl/vt_shadow.sv
module vt_shadow
  import crtc_vt_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    load,
  input  vt_cfg_t cfg_in,
  output vt_cfg_t cfg_q
);
  vt_cfg_t cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (load) cfg_d = cfg_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_d;
  end
endmodule

// File: rtl/vt_counter.sv
module vt_counter
  import crtc_vt_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    line_stb,
  input  vt_cfg_t cfg,
  output vt_pos_t pos_q,
  output logic    boundary
);
  localparam logic [LINE_W-1:0] LINE_ONE = LINE_W'(1);
  localparam logic [ROW_W-1:0]  ROW_ONE  = ROW_W'(1);
  localparam logic [RAS_W-1:0]  RAS_ONE  = RAS_W'(1);
  localparam logic [FINE_W:0]   FINE_ONE = (FINE_W+1)'(1);

  vt_pos_t       pos_d;
  logic          prime_q, prime_d;
  logic [FINE_W:0] fcnt_inc;
  logic          last_line;

  always_comb begin
    fcnt_inc  = {1'b0, pos_q.fcnt} + FINE_ONE;
    last_line = pos_q.in_fine ? (fcnt_inc == {1'b0, cfg.fine})
                              : ((pos_q.ras == cfg.ht) && (pos_q.row == cfg.tot) &&
                                 (cfg.fine == '0));
    pos_d    = pos_q;
    prime_d  = prime_q;
    boundary = 1'b0;
    if (line_stb) begin
      if (prime_q || last_line) begin
        boundary = 1'b1;
        pos_d    = '0;
        prime_d  = 1'b0;
      end else begin
        pos_d.line = pos_q.line + LINE_ONE;
        if (pos_q.in_fine) begin
          pos_d.fcnt = fcnt_inc[FINE_W-1:0];
        end else if (pos_q.ras != cfg.ht) begin
          pos_d.ras = pos_q.ras + RAS_ONE;
        end else if (pos_q.row != cfg.tot) begin
          pos_d.row = pos_q.row + ROW_ONE;
          pos_d.ras = '0;
        end else begin
          pos_d.in_fine = 1'b1;
          pos_d.fcnt    = '0;
          pos_d.ras     = '0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q   <= '0;
      prime_q <= 1'b1;
    end else begin
      pos_q   <= pos_d;
      prime_q <= prime_d;
    end
  end
endmodule

// File: rtl/vt_sync.sv
module vt_sync
  import crtc_vt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_stb,
  input  logic              trig,
  input  logic [SLEN_W-1:0] slen,
  output logic              vsync
);
  localparam logic [SLEN_W-1:0] SLEN_ONE = SLEN_W'(1);
  logic [SLEN_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (sync_stb) begin
      if ((cnt_q == '0) && trig) cnt_d = slen;
      else if (cnt_q != '0)      cnt_d = cnt_q - SLEN_ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign vsync = (cnt_q != '0);
endmodule

// File: rtl/crtc_vtiming.sv
module crtc_vtiming
  import crtc_vt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_stb,
  input  logic              half_stb,
  input  logic [ROW_W-1:0]  row_total,
  input  logic [RAS_W-1:0]  row_height,
  input  logic [FINE_W-1:0] fine_adj,
  input  logic [ROW_W-1:0]  disp_rows,
  input  logic [ROW_W-1:0]  sync_row,
  input  logic [SLEN_W-1:0] sync_len,
  input  logic [1:0]        scan_mode,
  output logic [LINE_W-1:0] line_cnt,
  output logic [ROW_W-1:0]  row_cnt,
  output logic [RAS_W-1:0]  ras_cnt,
  output logic              vblank,
  output logic              vsync,
  output logic              field_odd
);
  vt_cfg_t cfg_in, cfg_q;
  vt_pos_t pos;
  logic    boundary;
  logic    field_q, field_d;
  logic    line_q;
  logic    half_shift, sync_stb, sync_trig;

  always_comb begin
    cfg_in.tot   = row_total;
    cfg_in.ht    = row_height;
    cfg_in.fine  = fine_adj;
    cfg_in.disp  = disp_rows;
    cfg_in.srow  = sync_row;
    cfg_in.slen  = sync_len;
    cfg_in.ilace = (scan_mode == MODE_ILACE);
  end

  vt_shadow u_shadow (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (boundary),
    .cfg_in (cfg_in),
    .cfg_q  (cfg_q)
  );

  vt_counter u_counter (
    .clk      (clk),
    .rst_n    (rst_n),
    .line_stb (line_stb),
    .cfg      (cfg_q),
    .pos_q    (pos),
    .boundary (boundary)
  );

  always_comb begin
    field_d = field_q;
    if (boundary) field_d = (cfg_in.ilace && cfg_q.ilace) ? ~field_q : 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      field_q <= 1'b1;
      line_q  <= 1'b0;
    end else begin
      field_q <= field_d;
      line_q  <= line_stb;
    end
  end

  assign half_shift = cfg_q.ilace && !field_q;
  assign sync_stb   = half_shift ? half_stb : line_q;
  assign sync_trig  = !pos.in_fine && (pos.ras == '0) && (pos.row == cfg_q.srow);

  vt_sync u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .sync_stb (sync_stb),
    .trig     (sync_trig),
    .slen     (cfg_q.slen),
    .vsync    (vsync)
  );

  assign line_cnt  = pos.line;
  assign row_cnt   = pos.row;
  assign ras_cnt   = pos.ras;
  assign vblank    = pos.in_fine || (pos.row >= cfg_q.disp);
  assign field_odd = field_q;
endmodule

// File: rtl/crtc_vtiming_chk.sv
module crtc_vtiming_chk
  import crtc_vt_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              line_stb,
  input logic              half_stb,
  input logic [ROW_W-1:0]  row_total,
  input logic [RAS_W-1:0]  row_height,
  input logic [FINE_W-1:0] fine_adj,
  input logic [ROW_W-1:0]  disp_rows,
  input logic [ROW_W-1:0]  sync_row,
  input logic [SLEN_W-1:0] sync_len,
  input logic [1:0]        scan_mode,
  input logic [LINE_W-1:0] line_cnt,
  input logic [ROW_W-1:0]  row_cnt,
  input logic [RAS_W-1:0]  ras_cnt,
  input logic              vblank,
  input logic              vsync,
  input logic              field_odd
);
  localparam logic [LINE_W-1:0] STEP = LINE_W'(1);

  assert_line_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !line_stb |=> $stable(line_cnt));

  assert_line_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    line_stb |=> ((line_cnt == $past(line_cnt) + STEP) || (line_cnt == '0)));

  assert_row_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !line_stb |=> ($stable(row_cnt) && $stable(ras_cnt)));

  assert_field_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !line_stb |=> $stable(field_odd));

  assert_sync_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vsync) |-> ($past(half_stb) || $past(line_stb, 2)));

  assert_strobes_apart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(line_stb && half_stb));
endmodule

bind crtc_vtiming crtc_vtiming_chk u_chk (.*);

// File: tb/crtc_vtiming_bench.sv
`timescale 1ns/1ps
module crtc_vtiming_bench;
  import crtc_vt_pkg::*;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic              rst_n, line_stb, half_stb;
  logic [ROW_W-1:0]  row_total, disp_rows, sync_row;
  logic [RAS_W-1:0]  row_height;
  logic [FINE_W-1:0] fine_adj;
  logic [SLEN_W-1:0] sync_len;
  logic [1:0]        scan_mode;
  logic [LINE_W-1:0] line_cnt;
  logic [ROW_W-1:0]  row_cnt;
  logic [RAS_W-1:0]  ras_cnt;
  logic              vblank, vsync, field_odd;

  crtc_vtiming u_crtc_vtiming (.*);

  int n_chk = 0, n_bad = 0;
  bit run = 0, cmp_on = 0;
  int ph = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // strobe generator: line every 8 clocks, half strobe 4 clocks later
  always @(negedge clk) begin
    if (!run) begin
      line_stb = 0; half_stb = 0; ph = 0;
    end else begin
      line_stb = (ph == 0);
      half_stb = (ph == 4);
      ph = (ph + 1) % 8;
    end
  end

  // behavioural reference model
  int m_ln, m_tot, m_ht, m_fine, m_disp, m_sr, m_sl, m_vs;
  bit m_prime, m_il, m_odd, m_lq;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ln = 0; m_prime = 1; m_tot = 0; m_ht = 0; m_fine = 0; m_disp = 0;
      m_sr = 0; m_sl = 0; m_il = 0; m_odd = 1; m_vs = 0; m_lq = 0;
    end else begin
      int flen;
      bit sstb, trig, newil;
      flen = (m_tot + 1) * (m_ht + 1) + m_fine;
      sstb = (m_il && !m_odd) ? half_stb : m_lq;
      if (sstb) begin
        trig = (m_sr <= m_tot) && (m_ln == m_sr * (m_ht + 1));
        if (m_vs == 0 && trig) m_vs = m_sl;
        else if (m_vs > 0)     m_vs = m_vs - 1;
      end
      if (line_stb) begin
        if (m_prime || m_ln == flen - 1) begin
          newil = (scan_mode == 2'b11);
          m_odd = (newil && m_il) ? !m_odd : 1'b1;
          m_il = newil;
          m_tot = row_total; m_ht = row_height; m_fine = fine_adj;
          m_disp = disp_rows; m_sr = sync_row; m_sl = sync_len;
          m_ln = 0; m_prime = 0;
        end else begin
          m_ln = m_ln + 1;
        end
      end
      m_lq = line_stb;
    end
  end

  always @(negedge clk) begin
    if (rst_n && cmp_on) begin
      int rl, er, ea, bl;
      rl = (m_tot + 1) * (m_ht + 1);
      if (m_ln < rl) begin er = m_ln / (m_ht + 1); ea = m_ln % (m_ht + 1); end
      else begin er = m_tot; ea = 0; end
      bl = ((m_disp < m_tot + 1) ? m_disp : m_tot + 1) * (m_ht + 1);
      chk("R1", "line_cnt", int'(line_cnt), m_ln);
      chk("R2", "row_cnt", int'(row_cnt), er);
      chk("R2", "ras_cnt", int'(ras_cnt), ea);
      chk("R5", "vblank", int'(vblank), int'(m_ln >= bl));
      chk("R6", "vsync", int'(vsync), int'(m_vs != 0));
      chk("R8", "field_odd", int'(field_odd), int'(m_odd));
    end
  end

  task automatic wait_wrap();
    int prev;
    prev = line_cnt;
    forever begin
      @(negedge clk);
      if (line_cnt == 0 && prev != 0) return;
      prev = line_cnt;
    end
  endtask

  task automatic measure(output int mx, output int vsc, output int vbc, output int odd0);
    int prev;
    mx = 0; vsc = 0; vbc = 0; odd0 = field_odd;
    prev = line_cnt;
    forever begin
      if (int'(line_cnt) > mx) mx = line_cnt;
      vsc += vsync; vbc += vblank;
      @(negedge clk);
      if (line_cnt == 0 && prev != 0) return;
      prev = line_cnt;
    end
  endtask

  task automatic set_cfg(input int tot, input int ht, input int fine, input int disp,
                         input int sr, input int sl, input int mode);
    row_total = tot[ROW_W-1:0]; row_height = ht[RAS_W-1:0]; fine_adj = fine[FINE_W-1:0];
    disp_rows = disp[ROW_W-1:0]; sync_row = sr[ROW_W-1:0]; sync_len = sl[SLEN_W-1:0];
    scan_mode = mode[1:0];
  endtask

  initial begin : watchdog
    #(8 * 150000);
    n_chk++; n_bad++;
    $display("FAIL R1 watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    int mx, vsc, vbc, od;
    rst_n = 0; line_stb = 0; half_stb = 0;
    set_cfg(38, 7, 0, 25, 30, 3, 0);
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10", "reset line_cnt", int'(line_cnt), 0);
    chk("R10", "reset row_cnt", int'(row_cnt), 0);
    chk("R10", "reset ras_cnt", int'(ras_cnt), 0);
    chk("R10", "reset vsync", int'(vsync), 0);
    chk("R10", "reset vblank", int'(vblank), 1);
    chk("R10", "reset field_odd", int'(field_odd), 1);
    rst_n = 1; run = 1; cmp_on = 1;

    wait_wrap();
    measure(mx, vsc, vbc, od);
    chk("R1", "312-line field last index", mx, 311);
    chk("R6", "vsync clocks progressive", vsc, 24);
    chk("R5", "vblank clocks rows 25..38", vbc, 14 * 8 * 8);

    repeat (100) @(negedge clk);
    set_cfg(4, 2, 3, 3, 3, 2, 0);
    measure(mx, vsc, vbc, od);
    chk("R4", "field unchanged by mid-field write", mx, 311 - 0);
    measure(mx, vsc, vbc, od);
    chk("R3", "field with fine adjust last index", mx, 17);
    chk("R5", "vblank clocks incl fine lines", vbc, 72);
    chk("R6", "vsync clocks short field", vsc, 16);
    chk("R9", "progressive field flag", od, 1);

    scan_mode = 2'b11;
    measure(mx, vsc, vbc, od);
    chk("R4", "mode not yet active flag", od, 1);
    measure(mx, vsc, vbc, od);
    chk("R9", "first interlaced field odd", od, 1);
    chk("R6", "vsync clocks odd field", vsc, 16);
    measure(mx, vsc, vbc, od);
    chk("R8", "second interlaced field even", od, 0);
    chk("R7", "vsync clocks half-shifted field", vsc, 16);
    chk("R8", "even field length", mx, 17);
    measure(mx, vsc, vbc, od);
    chk("R8", "third interlaced field odd", od, 1);

    scan_mode = 2'b01;
    measure(mx, vsc, vbc, od);
    chk("R8", "last interlaced field even", od, 0);
    measure(mx, vsc, vbc, od);
    chk("R9", "mode 1 field flag", od, 1);
    measure(mx, vsc, vbc, od);
    chk("R9", "mode 1 flag constant", od, 1);

    sync_len = '0;
    measure(mx, vsc, vbc, od);
    measure(mx, vsc, vbc, od);
    chk("R6", "zero sync length gives no pulse", vsc, 0);

    set_cfg(9, 0, 0, 20, 2, 1, 0);
    measure(mx, vsc, vbc, od);
    measure(mx, vsc, vbc, od);
    chk("R2", "one-line rows field last index", mx, 9);
    chk("R5", "no blank when disp exceeds rows", vbc, 0);
    chk("R6", "one-line sync", vsc, 8);

    cmp_on = 0;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule